// File: doc/BRIEF.md
# UART Receive Buffer with Per-Character Error Tracking

This block sits between a UART's serial receiver and the host-facing register logic. Each character the receiver delivers is stored together with its own break, framing and parity error flags in a first-in first-out queue of up to 64 entries. The host pops characters one at a time from the receive holding port. It reads a status byte that always describes the character it is about to pop. Because the flags travel with the data, the host can read the status and then pop the data, and each error is matched to the right character.

The status byte also carries a summary bit that stays set while any stored character is errored, and a sticky overrun flag that a status read clears. It mirrors two emptiness signals from the transmit side: the holding register and the shift register. Occupancy is tracked by a three-state fill machine. `S_EMPTY` goes to `S_PARTIAL` on an accepted push. `S_PARTIAL` goes to `S_FULL` on a push without a pop when one slot is left. `S_PARTIAL` goes back to `S_EMPTY` on a pop without a push when one entry is left. `S_FULL` goes to `S_PARTIAL` on any pop. In `S_FULL` a push is never accepted and raises an overrun. In `S_EMPTY` a pop is never accepted.

Top module: `uart_rx_errfifo`

## Requirements
- R1: After reset the queue is empty and status bits 0 to 4 and bit 7 read 0. Bits 5 and 6 follow the transmit inputs, so with both inputs high the status reads 0x60.
- R2: Characters are popped in the order they were pushed, up to 64 stored at once. Status bit 0 is 1 exactly when at least one character is stored.
- R3: Status bit 2 (parity), bit 3 (framing) and bit 4 (break) show the flags of the head entry. They change only when the head is popped and are not altered by a status read. They read 0 when the queue is empty.
- R4: Status bit 7 is 1 while at least one stored entry has any error flag set, and 0 once none remain.
- R5: A push with the break flag set stores the character as 0x00, whatever data accompanies it.
- R6: A push while 64 characters are stored is discarded: contents and error summary are unchanged and status bit 1 (overrun) becomes 1.
- R7: A status read clears the overrun flag after the read cycle. An overrun in the same cycle as the read keeps the flag set.
- R8: A pop while the queue is empty changes nothing and returns 0x00 on the data output.
- R9: Status bit 5 equals the transmit-holding-empty input. Status bit 6 is 1 only when both transmit inputs are 1.
- R10: A push and a pop in the same cycle on a non-empty, non-full queue keep the occupancy constant. The error summary follows the incoming and outgoing flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Receiver delivers a character this cycle |
| push_data_i | input | 8 | Received character |
| push_brk_i | input | 1 | Break flag of the character |
| push_frm_i | input | 1 | Framing error flag (no valid stop bit) |
| push_par_i | input | 1 | Parity error flag |
| pop_i | input | 1 | Host reads the receive holding port this cycle |
| pop_data_o | output | 8 | Head character while popping, else 0x00 |
| stat_rd_i | input | 1 | Host reads the status byte this cycle |
| status_o | output | 8 | Receive and transmit line status byte |
| thr_empty_i | input | 1 | Transmit holding register is empty |
| tsr_empty_i | input | 1 | Transmit shift register is empty |

## Verification
Four input patterns drive the queue:
- Clean characters only. This shows ordering and the occupancy bit working with no error state involved.
- A mix of clean, parity, framing and break characters, popped one at a time. This tells head-entry reporting apart from the summary bit, and shows that break data is forced to zero.
- A fill to 64 characters followed by an errored push. This tells a discarded character apart from a stored one, because the summary bit must stay 0.
- Simultaneous push and pop pairs. These show whether the error tally nets an incoming error against an outgoing one, rather than only counting up or down.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        S_EMPTY   = 2'd0,
        S_PARTIAL = 2'd1,
        S_FULL    = 2'd2
    } fill_state_t;

endpackage

// File: rtl/rxq_fill_fsm.sv
module rxq_fill_fsm
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    output logic          push_ok_o,
    output logic          pop_ok_o,
    output logic          ovr_evt_o,
    output logic [AW-1:0] wr_ptr_o,
    output logic [AW-1:0] rd_ptr_o,
    output fill_state_t   state_o
);

    localparam logic [AW:0]   OCC_LAST = (AW+1)'(DEPTH - 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    fill_state_t   state_q, state_d;
    logic [AW:0]   occ_q;
    logic [AW-1:0] wr_q, rd_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    // next state and per-cycle outputs
    always_comb begin
        state_d   = state_q;
        push_ok_o = 1'b0;
        pop_ok_o  = 1'b0;
        ovr_evt_o = 1'b0;
        unique case (state_q)
            S_EMPTY: begin
                push_ok_o = push_i;
                if (push_i) state_d = (DEPTH == 1) ? S_FULL : S_PARTIAL;
            end
            S_PARTIAL: begin
                push_ok_o = push_i;
                pop_ok_o  = pop_i;
                if (push_i && !pop_i && occ_q == OCC_LAST)
                    state_d = S_FULL;
                else if (pop_i && !push_i && occ_q == (AW+1)'(1))
                    state_d = S_EMPTY;
            end
            S_FULL: begin
                pop_ok_o  = pop_i;
                ovr_evt_o = push_i;
                if (pop_i) state_d = (DEPTH == 1) ? S_EMPTY : S_PARTIAL;
            end
            default: state_d = S_EMPTY;
        endcase
    end

    // occupancy and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
            wr_q  <= '0;
            rd_q  <= '0;
        end else begin
            if (push_ok_o) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
            if (pop_ok_o)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
            if (push_ok_o && !pop_ok_o)      occ_q <= occ_q + 1'b1;
            else if (pop_ok_o && !push_ok_o) occ_q <= occ_q - 1'b1;
        end
    end

    assign wr_ptr_o = wr_q;
    assign rd_ptr_o = rd_q;
    assign state_o  = state_q;

    // R2: the empty state and a zero occupancy count always agree
    a_r2_empty_matches_occ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMPTY) == (occ_q == '0));

    // R6: a lone push into a full queue leaves occupancy unchanged
    a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FULL && push_i && !pop_i) |=> (occ_q == $past(occ_q)) && state_q == S_FULL);

    // R8: a lone pop on an empty queue keeps it empty
    a_r8_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMPTY && pop_i && !push_i) |=> (occ_q == '0));

    // R10: a push with a pop in the partial state keeps occupancy
    a_r10_push_pop_nets: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PARTIAL && push_i && pop_i) |=> $stable(occ_q));

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_ptr_i,
    input  rxq_entry_t    wr_entry_i,
    input  logic [AW-1:0] rd_ptr_i,
    output rxq_entry_t    rd_entry_o
);

    rxq_entry_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) slots[wr_ptr_i] <= wr_entry_i;
    end

    assign rd_entry_o = slots[rd_ptr_i];

endmodule

// File: rtl/rxq_err_tally.sv
module rxq_err_tally #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic [CW-1:0] count_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (inc_i && !dec_i) cnt_q <= cnt_q + 1'b1;
        else if (dec_i && !inc_i) cnt_q <= cnt_q - 1'b1;
    end

    assign count_o = cnt_q;

    // R4: the tally never decrements below zero
    a_r4_tally_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> !(dec_i && !inc_i));

    // R10: simultaneous increment and decrement leaves the tally unchanged
    a_r10_tally_nets: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i) |=> $stable(cnt_q));

endmodule

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_i,
    input  logic [7:0]  push_data_i,
    input  logic        push_brk_i,
    input  logic        push_frm_i,
    input  logic        push_par_i,
    input  logic        pop_i,
    output logic [7:0]  pop_data_o,
    input  logic        stat_rd_i,
    output logic [7:0]  status_o,
    input  logic        thr_empty_i,
    input  logic        tsr_empty_i
);

    logic          push_ok, pop_ok, ovr_evt;
    logic [AW-1:0] wr_ptr, rd_ptr;
    fill_state_t   fill_state;
    rxq_entry_t    in_entry, head;
    logic          head_valid, head_err, in_err;
    logic [CW-1:0] err_cnt;
    logic          ovr_q;

    rxq_fill_fsm #(.DEPTH(DEPTH)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .push_ok_o (push_ok),
        .pop_ok_o  (pop_ok),
        .ovr_evt_o (ovr_evt),
        .wr_ptr_o  (wr_ptr),
        .rd_ptr_o  (rd_ptr),
        .state_o   (fill_state)
    );

    // a break character is always stored as zero data
    always_comb begin
        in_entry.brk  = push_brk_i;
        in_entry.frm  = push_frm_i;
        in_entry.par  = push_par_i;
        in_entry.data = push_brk_i ? '0 : push_data_i;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .wr_en_i    (push_ok),
        .wr_ptr_i   (wr_ptr),
        .wr_entry_i (in_entry),
        .rd_ptr_i   (rd_ptr),
        .rd_entry_o (head)
    );

    assign head_valid = (fill_state != S_EMPTY);
    assign head_err   = head_valid && (head.brk || head.frm || head.par);
    assign in_err     = push_brk_i || push_frm_i || push_par_i;

    rxq_err_tally #(.DEPTH(DEPTH)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (push_ok && in_err),
        .dec_i   (pop_ok && head_err),
        .count_o (err_cnt)
    );

    // sticky overrun: a new overrun outranks a clearing read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ovr_q <= 1'b0;
        else if (ovr_evt)   ovr_q <= 1'b1;
        else if (stat_rd_i) ovr_q <= 1'b0;
    end

    assign pop_data_o = pop_ok ? head.data : 8'h00;

    always_comb begin
        status_o[0] = head_valid;
        status_o[1] = ovr_q;
        status_o[2] = head_valid && head.par;
        status_o[3] = head_valid && head.frm;
        status_o[4] = head_valid && head.brk;
        status_o[5] = thr_empty_i;
        status_o[6] = thr_empty_i && tsr_empty_i;
        status_o[7] = (err_cnt != '0);
    end

    // R7: a read without a fresh overrun leaves the flag clear
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !ovr_evt) |=> !status_o[1]);

    // R6: an overrun always shows in the status next cycle
    a_r6_overrun_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> status_o[1]);

    // R5: popping a break character yields zero data
    a_r5_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && status_o[4]) |-> (pop_data_o == 8'h00));

    // R4: the error summary implies a non-empty queue
    a_r4_summary_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7] |-> status_o[0]);

    // R3: without a pop, the head error bits hold across the next edge
    a_r3_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && !pop_i) |=> $stable(status_o[4:2]));

endmodule

// File: tb/sim_uart_rx_errfifo.sv
`timescale 1ns/100ps
module sim_uart_rx_errfifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 1'b0, push_brk_i = 1'b0, push_frm_i = 1'b0, push_par_i = 1'b0;
    logic [7:0] push_data_i = 8'h00;
    logic       pop_i = 1'b0, stat_rd_i = 1'b0;
    logic       thr_empty_i = 1'b1, tsr_empty_i = 1'b1;
    logic [7:0] pop_data_o, status_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    uart_rx_errfifo u0 (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i), .push_data_i(push_data_i),
        .push_brk_i(push_brk_i), .push_frm_i(push_frm_i), .push_par_i(push_par_i),
        .pop_i(pop_i), .pop_data_o(pop_data_o),
        .stat_rd_i(stat_rd_i), .status_o(status_o),
        .thr_empty_i(thr_empty_i), .tsr_empty_i(tsr_empty_i)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic op(input logic psh, input logic [7:0] d, input logic b, input logic f,
                      input logic p, input logic pp, input logic rd,
                      output logic [7:0] got, output logic [7:0] st);
        @(negedge clk);
        push_i = psh; push_data_i = d; push_brk_i = b; push_frm_i = f; push_par_i = p;
        pop_i = pp; stat_rd_i = rd;
        #1;
        got = pop_data_o;
        st  = status_o;
        @(posedge clk);
        #0.5;
        push_i = 1'b0; pop_i = 1'b0; stat_rd_i = 1'b0;
        push_brk_i = 1'b0; push_frm_i = 1'b0; push_par_i = 1'b0;
    endtask

    task automatic push(input logic [7:0] d, input logic b, input logic f, input logic p);
        logic [7:0] g, s;
        op(1'b1, d, b, f, p, 1'b0, 1'b0, g, s);
    endtask

    task automatic pop(output logic [7:0] got);
        logic [7:0] s;
        op(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, got, s);
    endtask

    task automatic rd_status(output logic [7:0] st);
        logic [7:0] g;
        op(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, g, st);
    endtask

    task automatic t_reset;
        logic [7:0] s;
        rd_status(s);
        check("R1 reset status", s, 8'h60);
    endtask

    task automatic t_order;
        logic [7:0] g, s;
        push(8'h41, 0, 0, 0); push(8'h42, 0, 0, 0); push(8'h43, 0, 0, 0);
        rd_status(s); check("R2 occupied", s, 8'h61);
        pop(g); check("R2 order 1st", g, 8'h41);
        pop(g); check("R2 order 2nd", g, 8'h42);
        pop(g); check("R2 order 3rd", g, 8'h43);
        rd_status(s); check("R2 drained", s, 8'h60);
    endtask

    task automatic t_head_err;
        logic [7:0] g, s;
        push(8'h11, 0, 0, 0); push(8'h22, 0, 0, 1);
        push(8'h33, 0, 1, 0); push(8'h55, 1, 0, 0);
        rd_status(s); check("R4 summary with clean head", s, 8'hE1);
        pop(g); check("R2 clean head data", g, 8'h11);
        rd_status(s); check("R3 parity at head", s, 8'hE5);
        rd_status(s); check("R3 read does not clear head bits", s, 8'hE5);
        pop(g); check("R3 parity char data", g, 8'h22);
        rd_status(s); check("R3 framing at head", s, 8'hE9);
        pop(g); check("R3 framing char data", g, 8'h33);
        rd_status(s); check("R3 break at head", s, 8'hF1);
        pop(g); check("R5 break stored as zero", g, 8'h00);
        rd_status(s); check("R4 summary clears", s, 8'h60);
    endtask

    task automatic t_fill;
        logic [7:0] g, s;
        for (int i = 0; i < 64; i++) push(8'(i + 1), 0, 0, 0);
        rd_status(s); check("R2 full clean", s, 8'h61);
        push(8'hEE, 0, 0, 1);
        rd_status(s); check("R6 overrun set, dropped error not counted", s, 8'h63);
        rd_status(s); check("R7 read cleared overrun", s, 8'h61);
        for (int i = 0; i < 64; i++) begin
            pop(g); check("R6 contents unchanged", g, 8'(i + 1));
        end
        rd_status(s); check("R6 dropped char absent", s, 8'h60);
    endtask

    task automatic t_empty_pop;
        logic [7:0] g, s;
        pop(g); check("R8 empty pop data", g, 8'h00);
        rd_status(s); check("R8 empty pop no effect", s, 8'h60);
        push(8'h77, 0, 0, 0);
        pop(g); check("R8 queue intact after empty pop", g, 8'h77);
    endtask

    task automatic t_tx;
        logic [7:0] s;
        thr_empty_i = 1'b1; tsr_empty_i = 1'b0;
        rd_status(s); check("R9 holding empty only", s, 8'h20);
        thr_empty_i = 1'b0; tsr_empty_i = 1'b1;
        rd_status(s); check("R9 shift empty only", s, 8'h00);
        thr_empty_i = 1'b0; tsr_empty_i = 1'b0;
        rd_status(s); check("R9 both busy", s, 8'h00);
        thr_empty_i = 1'b1; tsr_empty_i = 1'b1;
        rd_status(s); check("R9 both empty", s, 8'h60);
    endtask

    task automatic t_simul;
        logic [7:0] g, s;
        push(8'hA5, 0, 1, 0);
        rd_status(s); check("R10 one errored entry", s, 8'hE9);
        op(1'b1, 8'h5A, 0, 0, 0, 1'b1, 1'b0, g, s);
        check("R10 pop during push data", g, 8'hA5);
        rd_status(s); check("R10 error leaves, clean enters", s, 8'h61);
        op(1'b1, 8'h3C, 0, 0, 1, 1'b1, 1'b0, g, s);
        check("R10 second pop data", g, 8'h5A);
        rd_status(s); check("R10 clean leaves, error enters", s, 8'hE5);
        pop(g); check("R10 last data", g, 8'h3C);
        rd_status(s); check("R10 drained", s, 8'h60);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_order();
        t_head_err();
        t_fill();
        t_empty_pop();
        t_tx();
        t_simul();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule